// File: doc/BRIEF.md
# Host Control-Endpoint Transaction Sequencer

This block runs the host side of a control endpoint. Software reaches it through one 8-bit register. It writes request bits into that register, reads progress back from it, and clears sticky status flags by writing zero to them. The sequencer turns each pending request into a token for an abstract packet engine: SETUP, OUT, IN, or a status-stage form of OUT or IN. The packet engine returns exactly one outcome pulse for each accepted token.

From those outcomes the block keeps the DATA0/DATA1 toggle and retries unanswered tokens. It stops after three silent attempts in a row. It measures how long the device keeps answering NAK, counted in frame ticks, and halts when that lasts past a programmable limit. A STALL, a no-response error or a NAK timeout all halt the endpoint. While halted, the block sends nothing and discards pending ready bits, until software clears the halt flag and writes a fresh request.

The token output is a valid/ready stream. `tok_valid` rises with `tok_kind`, `tok_status` and `tok_data1` already set. All of these hold steady while `tok_ready` is low, and the token counts as accepted on the rising clock edge that sees both high. The packet engine may hold `tok_ready` low for as long as it needs. Outcome pulses are one cycle wide and are looked at only after a token has been accepted.

Top module: `ep0_host_seq`

## Requirements
- R1: After reset the register reads 0x00, `tok_valid` is low and `irq` is low.
- R2: Register bits, 7 down to 0: NAK-timeout halt, status-stage, IN request, no-response error, setup select, STALL received, TX ready, RX ready. A write handles them as follows.
  - Bits 7, 4 and 2 are cleared by writing 0 and kept by writing 1.
  - Bits 6, 5 and 3 take the written value.
  - Writing 1 to bit 1 sets it; writing 0 to bit 1 has no effect.
  - Bit 0 ignores writes.
- R3: A pending TX ready (bit 1) issues an OUT token, or a SETUP token if bit 3 is set. Otherwise a pending IN request (bit 5) issues an IN token. The `tok_kind` codes are OUT=0, IN=1, SETUP=2. The token is held on the stream until accepted.
- R4: A SETUP token carries DATA0 (`tok_data1`=0), and its acceptance clears the data toggle. The first data OUT after an acknowledged SETUP therefore carries DATA1.
- R5: The toggle flips on each ACK of a non-status OUT/SETUP and on each data packet received for a non-status IN. A token issued with bit 6 set has `tok_status`=1 and carries DATA1, and its outcome leaves the toggle unchanged.
- R6: An ACK to an OUT or SETUP clears bits 1, 3 and 6 on the following edge. An ACK pulse that arrives while an IN is outstanding is ignored.
- R7: A data packet received for an IN sets bit 0 and clears bits 5 and 6. A one-cycle `svc_rx` pulse clears bit 0. If both happen in the same cycle, the set wins.
- R8: A NAK re-issues the same pending token.
- R9: Three consecutive no-response outcomes set bit 4. The retry count restarts on any device response (ACK, NAK, STALL, data) and on any write with bit 1 or bit 5 set.
- R10: A STALL outcome sets bit 2.
- R11: After a NAK, frame ticks are counted until some other response or a new request arrives. The tick that would take the count past `nak_limit` sets bit 7. A limit of 0 disables this.
- R12: While bit 7, 4 or 2 is set, no token is issued and bits 1 and 5 read 0, including just after a write that sets them. An outstanding token's outcome is dropped.
- R13: `irq` equals bit 4 OR bit 2 OR bit 7 OR (bit 0 AND `rx_irq_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| svc_rx | input | 1 | Pulse that clears RX ready |
| rx_irq_en | input | 1 | Enables RX ready as an interrupt source |
| frame_tick | input | 1 | One pulse per frame, for NAK timing |
| nak_limit | input | 5 | NAK duration limit in frames, 0 disables |
| tok_valid | output | 1 | Token offered to the packet engine |
| tok_ready | input | 1 | Packet engine accepts the token |
| tok_kind | output | 2 | OUT=0, IN=1, SETUP=2 |
| tok_status | output | 1 | Token belongs to a status stage |
| tok_data1 | output | 1 | Data PID for the packet: 1 = DATA1 |
| rsp_ack | input | 1 | Device acknowledged the OUT/SETUP |
| rsp_nak | input | 1 | Device answered NAK |
| rsp_stall | input | 1 | Device answered STALL |
| rsp_data | input | 1 | Data packet received for the IN |
| rsp_timeout | input | 1 | No response from the device |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench first targets toggle sequencing across a SETUP and a status stage. A design that does not clear the toggle when SETUP is accepted, or that lets a status stage flip it, sends the wrong data PID on the next OUT. It then breaks a run of timeouts with a NAK and, separately, with a fresh request write. A retry counter that misses either reset raises the error too early.

The NAK timer is driven to exactly its limit and then one tick past it, and also run with a zero limit. An off-by-one shows up as a halt that comes one frame too early or too late. A design that keeps ready bits while halted reveals it when a request is written with the error flag still held, because a token then escapes.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2
  } tok_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  localparam int B_NAKTO = 7;
  localparam int B_STAT  = 6;
  localparam int B_INREQ = 5;
  localparam int B_ERR   = 4;
  localparam int B_SETUP = 3;
  localparam int B_STALL = 2;
  localparam int B_TXRDY = 1;
  localparam int B_RXRDY = 0;

endpackage

// File: rtl/ep0_retry_ctr.sv
module ep0_retry_ctr #(
  parameter int MAX_TRIES = 3,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (clr)                                cnt_q <= '0;
    else if (inc && cnt_q != CW'(MAX_TRIES))     cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == CW'(MAX_TRIES - 1));

  // R9
  retry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

endmodule

// File: rtl/ep0_nak_timer.sv
module ep0_nak_timer #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nak,
  input  logic          clr,
  input  logic          tick,
  input  logic [LW-1:0] limit,
  output logic          expire
);

  logic          active_q;
  logic [LW-1:0] cnt_q;

  assign expire = active_q && tick && (limit != '0) && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr || expire) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (nak)             active_q <= 1'b1;
      if (active_q && tick) cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R11
  nak_expire_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !active_q && (cnt_q == '0));

endmodule

// File: rtl/ep0_data_toggle.sv
module ep0_data_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic tog
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) tog <= 1'b0;
    else if (flip)     tog <= ~tog;
  end

  // R4
  toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tog);

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clr) |=> (tog != $past(tog)));

endmodule

// File: rtl/ep0_host_seq.sv
module ep0_host_seq
  import ep0_seq_pkg::*;
#(
  parameter int RETRY_MAX = 3,
  parameter int NAK_LIM_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 svc_rx,
  input  logic                 rx_irq_en,
  input  logic                 frame_tick,
  input  logic [NAK_LIM_W-1:0] nak_limit,
  output logic                 tok_valid,
  input  logic                 tok_ready,
  output logic [1:0]           tok_kind,
  output logic                 tok_status,
  output logic                 tok_data1,
  input  logic                 rsp_ack,
  input  logic                 rsp_nak,
  input  logic                 rsp_stall,
  input  logic                 rsp_data,
  input  logic                 rsp_timeout,
  output logic                 irq
);

  logic naktmo_q, status_q, inreq_q, err_q, setup_q, stall_q, txrdy_q, rxrdy_q;
  logic n_naktmo, n_status, n_inreq, n_err, n_setup, n_stall, n_txrdy, n_rxrdy;
  seq_state_e state_q, n_state;
  tok_kind_e  kind_q, n_kind;
  logic       stat_q, n_stat;
  logic halt_q, hs, in_wait, ev_ack, ev_data, ev_nak, ev_stall, ev_to;
  logic dev_rsp, new_req, retry_last, err_set, nak_expire, tog_q;
  logic unused_wbit;

  assign unused_wbit = reg_wdata[B_RXRDY];
  assign halt_q   = naktmo_q | err_q | stall_q;
  assign tok_valid = (state_q == ST_ISSUE);
  assign hs       = tok_valid && tok_ready;
  assign in_wait  = (state_q == ST_WAIT);
  assign ev_ack   = in_wait && rsp_ack && (kind_q != TK_IN);
  assign ev_data  = in_wait && rsp_data && (kind_q == TK_IN);
  assign ev_nak   = in_wait && rsp_nak;
  assign ev_stall = in_wait && rsp_stall;
  assign ev_to    = in_wait && rsp_timeout;
  assign dev_rsp  = ev_ack || ev_data || ev_nak || ev_stall;
  assign new_req  = reg_wr && (reg_wdata[B_TXRDY] || reg_wdata[B_INREQ]);
  assign err_set  = ev_to && retry_last;

  ep0_retry_ctr #(.MAX_TRIES(RETRY_MAX)) u_retry (
    .clk(clk), .rst_n(rst_n), .inc(ev_to), .clr(dev_rsp || new_req), .last(retry_last)
  );

  ep0_nak_timer #(.LW(NAK_LIM_W)) u_naktmr (
    .clk(clk), .rst_n(rst_n), .nak(ev_nak),
    .clr(ev_ack || ev_data || ev_stall || new_req),
    .tick(frame_tick), .limit(nak_limit), .expire(nak_expire)
  );

  ep0_data_toggle u_tog (
    .clk(clk), .rst_n(rst_n),
    .clr(hs && (kind_q == TK_SETUP)),
    .flip((ev_ack || ev_data) && !stat_q),
    .tog(tog_q)
  );

  // register next-state: software write first, hardware events override
  always_comb begin
    n_naktmo = naktmo_q; n_status = status_q; n_inreq = inreq_q; n_err = err_q;
    n_setup  = setup_q;  n_stall  = stall_q;  n_txrdy = txrdy_q; n_rxrdy = rxrdy_q;
    if (reg_wr) begin
      n_naktmo = naktmo_q & reg_wdata[B_NAKTO];
      n_err    = err_q    & reg_wdata[B_ERR];
      n_stall  = stall_q  & reg_wdata[B_STALL];
      n_status = reg_wdata[B_STAT];
      n_inreq  = reg_wdata[B_INREQ];
      n_setup  = reg_wdata[B_SETUP];
      if (reg_wdata[B_TXRDY]) n_txrdy = 1'b1;
    end
    if (ev_ack) begin
      n_txrdy = 1'b0; n_status = 1'b0; n_setup = 1'b0;
    end
    if (ev_data) begin
      n_rxrdy = 1'b1; n_inreq = 1'b0; n_status = 1'b0;
    end else if (svc_rx) begin
      n_rxrdy = 1'b0;
    end
    if (ev_stall)   n_stall  = 1'b1;
    if (err_set)    n_err    = 1'b1;
    if (nak_expire) n_naktmo = 1'b1;
    if (n_naktmo || n_err || n_stall) begin
      n_txrdy = 1'b0; n_inreq = 1'b0;
    end
  end

  always_comb begin
    n_state = state_q; n_kind = kind_q; n_stat = stat_q;
    unique case (state_q)
      ST_IDLE: if (!halt_q && (txrdy_q || inreq_q)) begin
        n_state = ST_ISSUE;
        n_stat  = status_q;
        if (txrdy_q) n_kind = setup_q ? TK_SETUP : TK_OUT;
        else         n_kind = TK_IN;
      end
      ST_ISSUE: if (tok_ready) n_state = ST_WAIT;
      ST_WAIT:  if (halt_q || dev_rsp || ev_to) n_state = ST_IDLE;
      default:  n_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {naktmo_q, status_q, inreq_q, err_q, setup_q, stall_q, txrdy_q, rxrdy_q} <= '0;
      state_q <= ST_IDLE;
      kind_q  <= TK_OUT;
      stat_q  <= 1'b0;
    end else begin
      {naktmo_q, status_q, inreq_q, err_q, setup_q, stall_q, txrdy_q, rxrdy_q} <=
        {n_naktmo, n_status, n_inreq, n_err, n_setup, n_stall, n_txrdy, n_rxrdy};
      state_q <= n_state;
      kind_q  <= n_kind;
      stat_q  <= n_stat;
    end
  end

  assign reg_rdata  = {naktmo_q, status_q, inreq_q, err_q, setup_q, stall_q, txrdy_q, rxrdy_q};
  assign tok_kind   = kind_q;
  assign tok_status = stat_q;
  assign tok_data1  = stat_q ? 1'b1 : ((kind_q == TK_SETUP) ? 1'b0 : tog_q);
  assign irq        = err_q | stall_q | naktmo_q | (rxrdy_q & rx_irq_en);

  // R3
  tok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ready) |=> tok_valid && $stable(tok_kind) && $stable(tok_status));

  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && halt_q) |=> !tok_valid);

  // R7
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> rxrdy_q && !inreq_q);

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_q && !txrdy_q && !inreq_q);

  // R10
  stall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> stall_q);

endmodule

// File: tb/ep0_host_seq_tb.sv
module ep0_host_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       svc_rx = 1'b0, rx_irq_en = 1'b0, frame_tick = 1'b0;
  logic [4:0] nak_limit = 5'd0;
  logic       tok_valid, tok_ready = 1'b0;
  logic [1:0] tok_kind;
  logic       tok_status, tok_data1;
  logic       rsp_ack = 1'b0, rsp_nak = 1'b0, rsp_stall = 1'b0, rsp_data = 1'b0, rsp_timeout = 1'b0;
  logic       irq;

  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  ep0_host_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .svc_rx(svc_rx), .rx_irq_en(rx_irq_en), .frame_tick(frame_tick), .nak_limit(nak_limit),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_kind(tok_kind),
    .tok_status(tok_status), .tok_data1(tok_data1),
    .rsp_ack(rsp_ack), .rsp_nak(rsp_nak), .rsp_stall(rsp_stall), .rsp_data(rsp_data),
    .rsp_timeout(rsp_timeout), .irq(irq)
  );

  // behavioural reference model
  int m_st = 0, m_kind = 0, m_retry = 0, m_ticks = 0;
  bit m_stat = 0, m_tog = 0, m_non = 0;
  bit [7:0] m_reg = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_kind = 0; m_retry = 0; m_ticks = 0;
      m_stat = 0; m_tog = 0; m_non = 0; m_reg = '0;
    end else begin
      bit halted, hs, w, ack, dat, nak, stl, to, nreq, errset, expire;
      bit [7:0] r;
      halted = m_reg[7] || m_reg[4] || m_reg[2];
      hs   = (m_st == 1) && tok_ready;
      w    = (m_st == 2);
      ack  = w && rsp_ack && m_kind != 1;
      dat  = w && rsp_data && m_kind == 1;
      nak  = w && rsp_nak;
      stl  = w && rsp_stall;
      to   = w && rsp_timeout;
      nreq = reg_wr && (reg_wdata[1] || reg_wdata[5]);
      errset = to && (m_retry == 2);
      expire = m_non && frame_tick && (nak_limit != 0) && (m_ticks == int'(nak_limit));
      r = m_reg;
      if (reg_wr) begin
        r[7] = m_reg[7] && reg_wdata[7];
        r[4] = m_reg[4] && reg_wdata[4];
        r[2] = m_reg[2] && reg_wdata[2];
        r[6] = reg_wdata[6]; r[5] = reg_wdata[5]; r[3] = reg_wdata[3];
        if (reg_wdata[1]) r[1] = 1;
      end
      if (ack) begin r[1] = 0; r[6] = 0; r[3] = 0; end
      if (dat) begin r[0] = 1; r[5] = 0; r[6] = 0; end
      else if (svc_rx) r[0] = 0;
      if (stl) r[2] = 1;
      if (errset) r[4] = 1;
      if (expire) r[7] = 1;
      if (r[7] || r[4] || r[2]) begin r[1] = 0; r[5] = 0; end
      if (hs && m_kind == 2) m_tog = 0;
      else if ((ack || dat) && !m_stat) m_tog = !m_tog;
      if (ack || dat || nak || stl || nreq) m_retry = 0;
      else if (to && m_retry < 3) m_retry++;
      if (ack || dat || stl || nreq || expire) begin m_non = 0; m_ticks = 0; end
      else begin
        if (m_non && frame_tick) m_ticks++;
        if (nak) m_non = 1;
      end
      case (m_st)
        0: if (!halted && (m_reg[1] || m_reg[5])) begin
             m_st = 1; m_stat = m_reg[6];
             m_kind = m_reg[1] ? (m_reg[3] ? 2 : 0) : 1;
           end
        1: if (tok_ready) m_st = 2;
        default: if (halted || ack || dat || nak || stl || to) m_st = 0;
      endcase
      m_reg = r;
    end
  end

  function automatic bit [13:0] exp_vec();
    bit d1;
    d1 = m_stat ? 1'b1 : ((m_kind == 2) ? 1'b0 : m_tog);
    return {m_reg, (m_st == 1), 2'(m_kind), m_stat, d1,
            (m_reg[4] || m_reg[2] || m_reg[7] || (m_reg[0] && rx_irq_en))};
  endfunction

  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      total++;
      if ({reg_rdata, tok_valid, tok_kind, tok_status, tok_data1, irq} !== exp_vec()) begin
        bad++;
        $display("FAIL %s model compare: actual=%h expected=%h", phase,
                 {reg_rdata, tok_valid, tok_kind, tok_status, tok_data1, irq}, exp_vec());
      end
    end
  end

  task automatic check(string tag, int act, int expv, string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic wr(bit [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // code: 0 ack, 1 nak, 2 stall, 3 data, 4 timeout, 5 none
  task automatic pulse_rsp(int code);
    rsp_ack = (code == 0); rsp_nak = (code == 1); rsp_stall = (code == 2);
    rsp_data = (code == 3); rsp_timeout = (code == 4);
    @(negedge clk);
    {rsp_ack, rsp_nak, rsp_stall, rsp_data, rsp_timeout} = '0;
  endtask

  task automatic serve(int code, int dly, int exp_d1, int exp_kind);
    int n = 0;
    while (!tok_valid && n < 50) begin @(negedge clk); n++; end
    check(phase, tok_valid, 1, "token offered");
    if (exp_kind >= 0) check(phase, tok_kind, exp_kind, "token kind");
    if (exp_d1 >= 0) check(phase, tok_data1, exp_d1, "data pid");
    idle(dly);
    tok_ready = 1'b1;
    @(negedge clk);
    tok_ready = 1'b0;
    @(negedge clk);
    if (code != 5) pulse_rsp(code);
  endtask

  task automatic tick();
    frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0; @(negedge clk);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    check("R1", reg_rdata, 8'h00, "reset reg");
    check("R1", tok_valid, 0, "reset valid");
    check("R1", irq, 0, "reset irq");

    phase = "R2";
    wr(8'h48); idle(3);
    check("R2", reg_rdata, 8'h48, "status+setup written");
    check("R2", tok_valid, 0, "no token without ready");
    wr(8'h01); idle(1);
    check("R2", reg_rdata, 8'h00, "bit0 ignores writes");

    phase = "R4";
    wr(8'h0A);
    serve(0, 3, 0, 2);
    idle(2);
    check("R6", reg_rdata, 8'h00, "ack clears tx/setup");
    phase = "R5";
    wr(8'h02);
    serve(0, 0, 1, 0);
    idle(1);
    phase = "R8";
    wr(8'h02);
    serve(1, 0, 0, 0);
    serve(1, 1, 0, 0);
    serve(0, 0, 0, 0);
    idle(2);

    phase = "R7";
    rx_irq_en = 1'b1;
    wr(8'h20);
    serve(3, 0, 1, 1);
    idle(1);
    check("R7", reg_rdata, 8'h01, "rx ready set, in req cleared");
    check("R13", irq, 1, "rx irq enabled");
    svc_rx = 1'b1; @(negedge clk); svc_rx = 1'b0;
    check("R7", reg_rdata, 8'h00, "svc clears rx ready");
    rx_irq_en = 1'b0;

    phase = "R5";
    wr(8'h60);
    serve(3, 0, 1, 1);
    idle(1);
    check("R13", irq, 0, "rx irq masked");
    svc_rx = 1'b1; @(negedge clk); svc_rx = 1'b0;
    wr(8'h42);
    serve(0, 0, 1, 0);
    wr(8'h02);
    serve(0, 0, 0, 0);
    idle(2);

    phase = "R9";
    wr(8'h02);
    serve(4, 0, -1, 0); serve(4, 0, -1, 0); serve(1, 0, -1, 0);
    serve(4, 0, -1, 0); serve(4, 0, -1, 0);
    check("R9", reg_rdata[4], 0, "two timeouts after nak");
    serve(4, 0, -1, 0);
    idle(1);
    check("R9", reg_rdata, 8'h10, "error after three");
    check("R13", irq, 1, "error irq");
    idle(8);
    check("R12", tok_valid, 0, "halted, no token");
    phase = "R12";
    wr(8'h12); idle(3);
    check("R12", reg_rdata, 8'h10, "ready discarded while halted");
    check("R12", tok_valid, 0, "still no token");
    wr(8'h00);
    phase = "R9";
    wr(8'h02);
    serve(4, 0, -1, 0); serve(4, 0, -1, 0);
    wr(8'h02);
    serve(4, 0, -1, 0); serve(4, 0, -1, 0);
    check("R9", reg_rdata[4], 0, "new request restarts count");
    serve(0, 0, -1, 0);
    idle(2);

    phase = "R10";
    wr(8'h02);
    serve(2, 0, -1, 0);
    idle(1);
    check("R10", reg_rdata, 8'h04, "stall flag");
    check("R13", irq, 1, "stall irq");
    wr(8'h00);

    phase = "R11";
    nak_limit = 5'd3;
    wr(8'h02);
    serve(1, 0, -1, 0);
    serve(5, 0, -1, 0);
    tick(); tick(); tick();
    check("R11", reg_rdata[7], 0, "at limit, no halt");
    tick();
    check("R11", reg_rdata, 8'h80, "past limit halts");
    idle(4);
    check("R11", tok_valid, 0, "nak halt silent");
    wr(8'h00);
    nak_limit = 5'd0;
    wr(8'h02);
    serve(1, 0, -1, 0);
    serve(5, 0, -1, 0);
    repeat (40) tick();
    check("R11", reg_rdata, 8'h02, "limit zero never halts");
    pulse_rsp(0);
    idle(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule